// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This issue-stage block looks at the two oldest decoded instructions each cycle and decides whether both go out together or only the older one does. An instruction paired in the first slot runs in the memory pipe. An instruction paired in the second slot runs in the function pipe. The decision comes from which classes each slot accepts, from the fact that the function pipe takes only one operation per cycle, from the rule that a branch ends the bundle, and from the rule that unknown or multi-op instructions issue alone.

The result is registered. `issue_valid` shows which candidates dispatched. `pipe_sel` shows the pipe each one was steered to. When only the older instruction goes, the surrounding issue logic moves the younger one up to the older position for the next cycle. This block checks no data dependences and tracks no long-latency unit occupancy.

Top module: `pair_issue_check`

## Requirements
- R1: A synchronous reset drives `issue_valid` and `pipe_sel` to zero. The outputs follow the inputs one clock later.
- R2: When `old_vld` is low, nothing issues. When `old_vld` is high, the older instruction always issues (`issue_valid[0]`). The younger instruction (`issue_valid[1]`) never issues without the older one.
- R3: The class codes are: 0 integer ALU, 1 load, 2 store, 3 integer multiply, 4 integer divide, 5 branch/jump/call, 6 FP add, 7 FP multiply, 8 FP divide/sqrt, 9 register-file transfer, 10 to 15 unknown/multi-op. The first slot accepts {0,1,2,9}. The second slot accepts {0,3,4,5,6,7,8,9}. If the older instruction fits the first slot and the younger fits the second, both issue, with `pipe_sel` = 2'b10 (older in memory pipe = 0, younger in function pipe = 1).
- R4: If the older instruction does not fit the first slot, the pair is swapped only when the younger fits the first slot and the older fits the second. Both then issue with `pipe_sel` = 2'b01. An integer ALU followed by a load is not swapped, so it issues single.
- R5: Two memory operations (any mix of load and store) never pair.
- R6: Two function-pipe-only operations (classes 3 to 8) never pair, because the function pipe accepts one per cycle.
- R7: An older branch issues alone. A younger branch pairs behind an older first-slot instruction.
- R8: A class of 10 or above in either position makes the older instruction issue alone.
- R9: A register-file transfer (class 9) pairs exactly like an integer ALU operation, in either slot.
- R10: An older instruction that issues alone reports the function pipe (`pipe_sel[0]`=1) for classes 3 to 8 and the memory pipe otherwise. `pipe_sel[1]` is 0 whenever the younger instruction does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| old_vld | input | 1 | Older candidate present |
| old_cls | input | CLS_W | Older candidate class code |
| yng_vld | input | 1 | Younger candidate present |
| yng_cls | input | CLS_W | Younger candidate class code |
| issue_valid | output | 2 | Bit 0 older issued, bit 1 younger issued |
| pipe_sel | output | 2 | Per instruction: 0 memory pipe, 1 function pipe |

## Verification
The pair-acceptance decision and the slot-swap steering can land in the same cycle. This happens when a function-pipe instruction is older than a load, store or ALU operation. Such pairs, for example FP add before load and integer divide before transfer, are driven next to their unswapped mirrors. Both issue bits and the crossed pipe selections are compared. Bundle closing by a branch is also provoked with the branch in each position, and a branch with a first-slot partner must give different results depending on its position.

// File: rtl/pair_issue_check.sv
module pair_issue_check #(
  parameter int CLS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             old_vld,
  input  logic [CLS_W-1:0] old_cls,
  input  logic             yng_vld,
  input  logic [CLS_W-1:0] yng_cls,
  output logic [1:0]       issue_valid,
  output logic [1:0]       pipe_sel
);
  localparam logic [CLS_W-1:0] C_ALU   = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_LD    = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_ST    = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_IMUL  = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_IDIV  = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_BR    = CLS_W'(5);
  localparam logic [CLS_W-1:0] C_FADD  = CLS_W'(6);
  localparam logic [CLS_W-1:0] C_FMUL  = CLS_W'(7);
  localparam logic [CLS_W-1:0] C_FDIV  = CLS_W'(8);
  localparam logic [CLS_W-1:0] C_XFER  = CLS_W'(9);
  localparam logic [CLS_W-1:0] C_MULTI = CLS_W'(10);

  function automatic logic slot0_ok(input logic [CLS_W-1:0] c);
    return (c == C_ALU) || (c == C_LD) || (c == C_ST) || (c == C_XFER);
  endfunction

  function automatic logic fpipe_only(input logic [CLS_W-1:0] c);
    return (c == C_IMUL) || (c == C_IDIV) || (c == C_BR) ||
           (c == C_FADD) || (c == C_FMUL) || (c == C_FDIV);
  endfunction

  function automatic logic slot1_ok(input logic [CLS_W-1:0] c);
    return (c == C_ALU) || (c == C_XFER) || fpipe_only(c);
  endfunction

  logic solo_o, solo_y, can_pair, direct, swap, pair;
  logic [1:0] nxt_v, nxt_p;

  assign solo_o   = old_cls >= C_MULTI;
  assign solo_y   = yng_cls >= C_MULTI;
  assign can_pair = old_vld && yng_vld && !solo_o && !solo_y && (old_cls != C_BR);
  assign direct   = slot0_ok(old_cls) && slot1_ok(yng_cls);
  assign swap     = !slot0_ok(old_cls) && slot0_ok(yng_cls) && slot1_ok(old_cls);
  assign pair     = can_pair && (direct || swap);

  always_comb begin
    nxt_v = 2'b00;
    nxt_p = 2'b00;
    if (old_vld) begin
      nxt_v = pair ? 2'b11 : 2'b01;
      if (pair)
        nxt_p = direct ? 2'b10 : 2'b01;
      else
        nxt_p = {1'b0, fpipe_only(old_cls)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 2'b00;
      pipe_sel    <= 2'b00;
    end else begin
      issue_valid <= nxt_v;
      pipe_sel    <= nxt_p;
    end
  end
endmodule

module pair_issue_check_sva #(
  parameter int CLS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             old_vld,
  input logic [CLS_W-1:0] old_cls,
  input logic             yng_vld,
  input logic [CLS_W-1:0] yng_cls,
  input logic [1:0]       issue_valid,
  input logic [1:0]       pipe_sel
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (issue_valid == 2'b00 && pipe_sel == 2'b00));

  // R2
  young_needs_old_chk: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid[1] && !issue_valid[0]));

  // R2
  old_always_goes_chk: assert property (@(posedge clk) disable iff (rst)
    old_vld |=> issue_valid[0]);

  // R2
  idle_nothing_chk: assert property (@(posedge clk) disable iff (rst)
    !old_vld |=> issue_valid == 2'b00);

  // R3
  pair_split_pipes_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid == 2'b11) |-> (pipe_sel[0] != pipe_sel[1]));

  // R7
  branch_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (old_vld && old_cls == CLS_W'(5)) |=> issue_valid == 2'b01);

  // R8
  multi_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (old_vld && (old_cls >= CLS_W'(10) || (yng_vld && yng_cls >= CLS_W'(10))))
      |=> issue_valid == 2'b01);

  // R5
  two_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (old_vld && yng_vld && (old_cls == CLS_W'(1) || old_cls == CLS_W'(2)) &&
     (yng_cls == CLS_W'(1) || yng_cls == CLS_W'(2))) |=> issue_valid == 2'b01);

  // R10
  lone_young_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid[1] |-> !pipe_sel[1]);
endmodule

bind pair_issue_check pair_issue_check_sva #(.CLS_W(CLS_W)) u_sva (
  .clk(clk), .rst(rst), .old_vld(old_vld), .old_cls(old_cls),
  .yng_vld(yng_vld), .yng_cls(yng_cls),
  .issue_valid(issue_valid), .pipe_sel(pipe_sel));

// File: tb/pair_issue_check_tb.sv
module pair_issue_check_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       old_vld = 1'b0, yng_vld = 1'b0;
  logic [3:0] old_cls = 4'd0, yng_cls = 4'd0;
  logic [1:0] issue_valid, pipe_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] v;
    logic [1:0] p;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  pair_issue_check #(.CLS_W(4)) u_dut (
    .clk(clk), .rst(rst), .old_vld(old_vld), .old_cls(old_cls),
    .yng_vld(yng_vld), .yng_cls(yng_cls),
    .issue_valid(issue_valid), .pipe_sel(pipe_sel));

  function automatic bit in_first(input int c);
    return c == 0 || c == 1 || c == 2 || c == 9;
  endfunction
  function automatic bit in_second(input int c);
    return c == 0 || c == 9 || (c >= 3 && c <= 8);
  endfunction

  function automatic exp_t predict(input bit ov, input int oc, input bit yv, input int yc, input string tag);
    exp_t e;
    e.tag = tag;
    e.v = 2'b00;
    e.p = 2'b00;
    if (ov) begin
      bit ok;
      ok = yv && oc < 10 && yc < 10 && oc != 5;
      if (ok && in_first(oc) && in_second(yc)) begin
        e.v = 2'b11; e.p = 2'b10;
      end else if (ok && !in_first(oc) && in_first(yc) && in_second(oc)) begin
        e.v = 2'b11; e.p = 2'b01;
      end else begin
        e.v = 2'b01;
        e.p = (oc >= 3 && oc <= 8) ? 2'b01 : 2'b00;
      end
    end
    return e;
  endfunction

  task automatic drv(input bit ov, input int oc, input bit yv, input int yc, input string tag);
    @(negedge clk);
    old_vld = ov; old_cls = 4'(oc);
    yng_vld = yv; yng_cls = 4'(yc);
    sb.push_back(predict(ov, oc, yv, yc, tag));
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (issue_valid !== e.v || pipe_sel !== e.p) begin
          errors++;
          $display("FAIL %s: got v=%b p=%b expected v=%b p=%b",
                   e.tag, issue_valid, pipe_sel, e.v, e.p);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (issue_valid !== 2'b00 || pipe_sel !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset: got v=%b p=%b expected v=00 p=00", issue_valid, pipe_sel);
    end
    @(negedge clk);
    rst = 1'b0;
    drv(0, 0, 1, 0, "R2 no older");
    drv(1, 0, 1, 3, "R3 alu+imul");
    drv(1, 1, 1, 6, "R3 load+fadd");
    drv(1, 2, 1, 0, "R3 store+alu");
    drv(1, 6, 1, 1, "R4 fadd+load swap");
    drv(1, 4, 1, 9, "R4 idiv+xfer swap");
    drv(1, 0, 1, 1, "R4 alu+load no swap");
    drv(1, 1, 1, 2, "R5 load+store");
    drv(1, 2, 1, 2, "R5 store+store");
    drv(1, 6, 1, 7, "R6 fadd+fmul");
    drv(1, 3, 1, 5, "R6 imul+branch");
    drv(1, 5, 1, 0, "R7 older branch");
    drv(1, 0, 1, 5, "R7 younger branch");
    drv(1, 10, 1, 0, "R8 older multi");
    drv(1, 0, 1, 15, "R8 younger unknown");
    drv(1, 9, 1, 8, "R9 xfer+fdiv");
    drv(1, 8, 1, 9, "R9 fdiv+xfer swap");
    drv(1, 7, 0, 0, "R10 fmul alone");
    drv(1, 1, 0, 0, "R10 load alone");
    drv(1, 12, 0, 0, "R10 multi alone");
    drv(0, 0, 0, 0, "R2 idle");
    for (int o = 0; o < 16; o++)
      for (int y = 0; y < 16; y++)
        drv(1, o, 1, y, "R3 sweep");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule